// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block is a memory-mapped peripheral with four identical 32-bit down-counters behind a simple register bus. The bus has an address, a write strobe, a read strobe, write data and combinational read data. A block-wide run control gates every channel, and each channel also has its own run control. Counting advances once for each cycle in which the `tick_en` input is high, so one fast-clock enable drives every channel.

Each channel has the following registers:
- a reload register that the count starts from and returns to after it reaches zero;
- a counter of underflow events;
- a one-bit event flag, cleared by writing a one to it;
- a one-bit mask that decides whether the flag drives the shared interrupt line.

Software that wants a free-running up-count sets the reload to all ones and reads the inverse of the count.

The count is never read live. A read of a channel's overflow register captures the running count into a snapshot. A later read of the current-value register returns that snapshot. Software therefore reads the overflow register first and the current value second, and gets a coherent pair.

Top module: `multi_timer`

## Requirements
- R1: After reset, the following read back as zero: the block control register, every channel's local enable, overflow count, snapshot, status and mask, and `irq`. Every reload register reads 0xFFFFFFFF, and each channel's count equals its reload.
- R2: Block registers: offset 0x00 is control, with the global enable in bit 0. Offset 0x10 is a read-only revision constant, default 0x00000102. Channel n (0..3) occupies base 0x20*(n+1). Its registers sit at these offsets from that base: configuration +0x00 (local enable, bit 0 only), reload +0x04, current value +0x08, overflow count +0x0C, status +0x10, clear +0x14, mask +0x18 (bit 0). Any other address reads zero, and writes to read-only registers are ignored.
- R3: A channel's count drops by one on each cycle where the global enable, its local enable and `tick_en` are all high. It holds in every other cycle while its local enable is set.
- R4: While a channel's local enable is clear, its count follows the reload register. Setting the enable therefore starts counting from the reload value.
- R5: On a counting cycle where the count is zero, the count reloads from the reload register, the 32-bit overflow count rises by one, and status bit 0 is set.
- R6: A read of the overflow register (read strobe high at that address) captures the count present in that cycle. Current-value reads return the last capture and are not refreshed by any other read.
- R7: Writing 1 to bit 0 of a channel's clear register clears its status bit. If an underflow happens in the same cycle, the status bit stays set.
- R8: `irq` is high exactly when some channel has both its status bit and its mask bit set. A mask of 0 keeps that channel off `irq`.
- R9: With reload 0xFFFFFFFF and N counting cycles since enable, the bitwise inverse of the captured current value equals N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count advance enable, one step per high cycle |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (triggers capture at overflow offsets) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | OR over channels of status AND mask |

## Verification
The bench reads the current value without a preceding overflow read and expects the stale captured value. A design that returns the live count would show the advanced value there.

It also runs channels into and past zero and checks that the reload value reappears and the overflow count steps by one. A design that wraps to 0xFFFFFFFF, or that reloads one tick late, would disagree on the count read after the wrap.

Three further cases each target a specific fault:
- A channel is held with the global enable off while ticks arrive. A design that ignores the global enable would show a moved count.
- An interrupt is raised with the mask at zero and then unmasked. A design that ignores the mask would raise `irq` early.
- Register writes land on the revision register and on upper configuration bits. A design with loose decode would read back those written values.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int CNT_W  = 32;
    localparam int NCH    = 4;
    localparam int OFS_W  = 5;

    localparam logic [CNT_W-1:0] RELOAD_RST = '1;
    localparam logic [CNT_W-1:0] REV_ID     = 32'h0000_0102;

    // block-level offsets (window 0)
    localparam logic [OFS_W-1:0] BLK_CTRL = 5'h00;
    localparam logic [OFS_W-1:0] BLK_REV  = 5'h10;

    // per-channel offsets inside a 0x20 window
    localparam logic [OFS_W-1:0] OFS_CFG = 5'h00;
    localparam logic [OFS_W-1:0] OFS_RLD = 5'h04;
    localparam logic [OFS_W-1:0] OFS_CUR = 5'h08;
    localparam logic [OFS_W-1:0] OFS_OVF = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_STS = 5'h10;
    localparam logic [OFS_W-1:0] OFS_CLR = 5'h14;
    localparam logic [OFS_W-1:0] OFS_MSK = 5'h18;

    typedef struct packed {
        logic cfg_wr;
        logic rld_wr;
        logic clr_wr;
        logic msk_wr;
        logic ovf_rd;
    } ch_strobe_t;

    typedef struct packed {
        logic             loc_en;
        logic             status;
        logic             mask;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] snap;
        logic [CNT_W-1:0] ovf;
    } ch_view_t;

    function automatic logic [CNT_W-1:0] bit_word(input logic b);
        return {{(CNT_W-1){1'b0}}, b};
    endfunction
endpackage

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             glob_en,
    input  ch_strobe_t       stb,
    input  logic [CNT_W-1:0] wdata,
    output ch_view_t         view,
    output logic             irq_src
);
    logic             loc_en, status, mask;
    logic [CNT_W-1:0] reload, count, ovf, snap;
    logic             run, wrap;

    assign run  = glob_en & loc_en & tick_en;
    assign wrap = run && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_en <= 1'b0;
            status <= 1'b0;
            mask   <= 1'b0;
            reload <= RELOAD_RST;
            count  <= RELOAD_RST;
            ovf    <= '0;
            snap   <= '0;
        end else begin
            if (stb.cfg_wr) loc_en <= wdata[0];
            if (stb.rld_wr) reload <= wdata;
            if (stb.msk_wr) mask   <= wdata[0];

            if (!loc_en)   count <= reload;
            else if (wrap) count <= reload;
            else if (run)  count <= count - 1'b1;

            if (wrap) ovf <= ovf + 1'b1;

            if (wrap)                         status <= 1'b1;
            else if (stb.clr_wr && wdata[0])  status <= 1'b0;

            if (stb.ovf_rd) snap <= count;
        end
    end

    assign view    = '{loc_en: loc_en, status: status, mask: mask,
                       reload: reload, snap: snap, ovf: ovf};
    assign irq_src = status & mask;

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && count != '0 && !stb.cfg_wr) |=> count == $past(count) - 1'b1);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (loc_en && !run && !stb.cfg_wr) |=> $stable(count));
    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && !stb.rld_wr && !stb.cfg_wr) |=> (count == reload) && status);
    // R5
    ovf_inc_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf == $past(ovf) + 1'b1);
    // R6
    snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
        stb.ovf_rd |=> snap == $past(count));
    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb.ovf_rd |=> $stable(snap));
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stb.clr_wr && wdata[0] && !wrap) |=> !status);
endmodule

// File: rtl/gpt_irq_merge.sv
module gpt_irq_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] src,
    output logic         irq
);
    assign irq = |src;
endmodule

// File: rtl/multi_timer.sv
module multi_timer
    import gpt_pkg::*;
#(
    parameter int               NUM_CH = NCH,
    parameter int               ADDR_W = $clog2(NUM_CH + 1) + OFS_W,
    parameter logic [CNT_W-1:0] REV    = REV_ID
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int WIN_W = ADDR_W - OFS_W;

    logic [WIN_W-1:0] win;
    logic [OFS_W-1:0] off;
    logic             glob_en;
    ch_view_t         view [NUM_CH];
    logic [NUM_CH-1:0] src_vec, st_vec, mk_vec;

    assign win = bus_addr[ADDR_W-1:OFS_W];
    assign off = bus_addr[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) glob_en <= 1'b0;
        else if (bus_we && win == '0 && off == BLK_CTRL) glob_en <= bus_wdata[0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_strobe_t stb;
        logic       hit;
        assign hit        = (win == WIN_W'(i + 1));
        assign stb.cfg_wr = hit && bus_we && off == OFS_CFG;
        assign stb.rld_wr = hit && bus_we && off == OFS_RLD;
        assign stb.clr_wr = hit && bus_we && off == OFS_CLR;
        assign stb.msk_wr = hit && bus_we && off == OFS_MSK;
        assign stb.ovf_rd = hit && bus_re && off == OFS_OVF;

        gpt_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick_en (tick_en),
            .glob_en (glob_en),
            .stb     (stb),
            .wdata   (bus_wdata),
            .view    (view[i]),
            .irq_src (src_vec[i])
        );
        assign st_vec[i] = view[i].status;
        assign mk_vec[i] = view[i].mask;
    end

    gpt_irq_merge #(.N(NUM_CH)) u_irq (.src(src_vec), .irq(irq));

    always_comb begin
        bus_rdata = '0;
        if (win == '0) begin
            case (off)
                BLK_CTRL: bus_rdata = bit_word(glob_en);
                BLK_REV:  bus_rdata = REV;
                default:  bus_rdata = '0;
            endcase
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (win == WIN_W'(i + 1)) begin
                case (off)
                    OFS_CFG: bus_rdata = bit_word(view[i].loc_en);
                    OFS_RLD: bus_rdata = view[i].reload;
                    OFS_CUR: bus_rdata = view[i].snap;
                    OFS_OVF: bus_rdata = view[i].ovf;
                    OFS_STS: bus_rdata = bit_word(view[i].status);
                    OFS_MSK: bus_rdata = bit_word(view[i].mask);
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq == |(st_vec & mk_vec));
    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (mk_vec == '0) |-> !irq);
    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && win == '0) |=> $stable(glob_en));
endmodule

// File: tb/multi_timer_bench.sv
`timescale 1ns/1ps
module multi_timer_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic [7:0]  bus_addr;
    logic        bus_we, bus_re;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    multi_timer u_multi_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // vector: {we, addr, wdata, expected}
    localparam int NV = 14;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h44, 32'h0,      32'hFFFF_FFFF}, // R1 reload reset
        {1'b1, 8'h44, 32'h5,      32'h0},
        {1'b0, 8'h44, 32'h0,      32'h5},         // R2 ch1 reload
        {1'b1, 8'h78, 32'h1,      32'h0},
        {1'b0, 8'h78, 32'h0,      32'h1},         // R2 ch2 mask
        {1'b1, 8'h00, 32'h1,      32'h0},
        {1'b0, 8'h00, 32'h0,      32'h1},         // R2 ctrl
        {1'b1, 8'h10, 32'hDEAD,   32'h0},
        {1'b0, 8'h10, 32'h0,      32'h0000_0102}, // R2 revision read-only
        {1'b1, 8'h80, 32'h81,     32'h0},
        {1'b0, 8'h80, 32'h0,      32'h1},         // R2 cfg bit0 only
        {1'b0, 8'h48, 32'h0,      32'h0},         // R6 snapshot reset
        {1'b0, 8'h1C, 32'h0,      32'h0},         // R2 unmapped
        {1'b0, 8'h9C, 32'h0,      32'h0}          // R2 unmapped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        rst = 1'b1; tick_en = 1'b0; bus_addr = '0; bus_we = 1'b0;
        bus_re = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(8'h00, v); check("R1 ctrl", v, 32'h0);
        rd(8'h30, v); check("R1 status", v, 32'h0);
        rd(8'h2C, v); check("R1 ovf", v, 32'h0);
        rd(8'h38, v); check("R1 mask", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], v);
                check($sformatf("R2 vec%0d", i), v, VEC[i][31:0]);
            end
        end

        // channel 0 counting, wrap, snapshot, irq
        wr(8'h24, 32'd3);
        wr(8'h20, 32'd1);
        ticks(2);
        rd(8'h2C, v); check("R5 ovf before wrap", v, 32'd0);
        rd(8'h28, v); check("R3 count after 2", v, 32'd1);
        ticks(2);
        rd(8'h30, v); check("R5 status on wrap", v, 32'd1);
        check("R8 masked irq low", {31'b0, irq}, 32'h0);
        rd(8'h28, v); check("R6 stale current", v, 32'd1);
        rd(8'h2C, v); check("R5 ovf after wrap", v, 32'd1);
        rd(8'h28, v); check("R5 reloaded count", v, 32'd3);
        wr(8'h38, 32'd1);
        #1 check("R8 irq unmasked", {31'b0, irq}, 32'h1);
        wr(8'h34, 32'd1);
        #1 check("R7 irq after clear", {31'b0, irq}, 32'h0);
        rd(8'h30, v); check("R7 status cleared", v, 32'd0);

        // R4: local enable clear tracks reload
        wr(8'h20, 32'd0);
        wr(8'h24, 32'd7);
        ticks(2);
        rd(8'h2C, v);
        rd(8'h28, v); check("R4 idle count follows reload", v, 32'd7);

        // R3 global enable gates counting
        wr(8'h00, 32'd0);
        wr(8'h40, 32'd1);
        ticks(3);
        rd(8'h4C, v);
        rd(8'h48, v); check("R3 global off holds", v, 32'd5);
        wr(8'h00, 32'd1);
        ticks(6);
        rd(8'h4C, v); check("R5 ch1 ovf", v, 32'd1);
        rd(8'h48, v); check("R5 ch1 reload after wrap", v, 32'd5);

        // R9 free-running up-count
        wr(8'h60, 32'd1);
        ticks(10);
        rd(8'h6C, v); check("R9 ovf zero", v, 32'd0);
        rd(8'h68, v); check("R9 inverse count", ~v, 32'd10);
        repeat (5) @(negedge clk);
        rd(8'h6C, v);
        rd(8'h68, v); check("R3 no tick holds", ~v, 32'd10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule